// File: doc/BRIEF.md
# Programmable CRC32 Register Engine

A memory-mapped CRC calculator on a plain 32-bit register bus. Software loads a starting value and a generator polynomial, then pushes message data into a data register one byte or one full word at a time. Each accepted data write is folded into a running 32-bit remainder in a single clock, whatever its width. Reading the data register returns the running remainder, optionally bit-reversed.

A control register selects how incoming data bits are ordered (untouched, mirrored inside each byte, or mirrored across the whole word) and whether the read value is mirrored. It also carries a self-clearing bit that reloads the remainder from the starting value. The ordering options can be changed between data writes without losing the remainder. This lets a driver feed the aligned middle of a buffer as words and the ragged ends as bytes.

The bus is a register interface, not a stream. Every write is accepted in the cycle it is presented, so there is no back-pressure. Reads are combinational from the word address.

Top module: `crc_reg_engine`

## Requirements
- R1: After reset the remainder and the starting-value register are 0xFFFFFFFF, the polynomial register is 0x04C11DB7 and the control register reads 0.
- R2: Writing the control register (word address 1, lane 0 enabled) with bit 0 set copies the starting-value register into the remainder; bit 0 always reads back as 0.
- R3: Word addresses are 0 data, 1 control, 2 starting value, 3 polynomial. The starting-value and polynomial registers are read/write, and each byte lane is updated only where its strobe is set.
- R4: A data write with all four strobes set folds 32 bits into the remainder MSB-first in one cycle, using the polynomial register (x^32 implicit): per bit, feedback = rem[31] xor bit, rem = rem<<1, xor poly if feedback.
- R5: A data write with exactly one strobe set folds only the byte on that lane, MSB-first. Any other strobe pattern leaves the remainder unchanged.
- R6: Control bits 6:5 order the input. Bit 5 clear means no reordering. 01 mirrors each byte in place. 11 mirrors the full 32-bit word (lane 0 bit 0 is absorbed first). A byte write is mirrored whenever bit 5 is set.
- R7: Control bit 7 set makes a data-register read return the remainder bit-reversed; the remainder itself is not altered.
- R8: A control write with bit 0 clear changes the ordering options but leaves the remainder unchanged.
- R9: Starting value 0xFFFFFFFF, polynomial 0x04C11DB7, byte-mirrored input, mirrored output and a final XOR with 0xFFFFFFFF give 0xCBF43926 for "123456789", for both byte-only and mixed word/byte feeding.
- R10: A control write that sets bit 0 and changes the ordering in the same cycle reloads the remainder, and the next data write uses the new ordering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word_addr | input | 2 | Word address of the register accessed |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte-lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |

## Verification
Two functions can meet in one cycle: a reload and a change of input ordering arrive in the same control write. The bench writes a control value that sets bit 0 and switches the ordering together, then sends a word. It judges the result against a behavioural model that reloads first and then applies the new ordering. A data write also overlaps a read of the same register. The bench compares the read data on every clock, so it expects the value from before the write during the write cycle and the new value afterwards.

// File: rtl/crcx_pkg.sv
package crcx_pkg;
  localparam int CRC_W  = 32;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_INIT = 2'd2,
    SEL_POLY = 2'd3
  } reg_sel_e;

  localparam int CTL_RELOAD_BIT = 0;
  localparam int CTL_ORDER_LO   = 5;
  localparam int CTL_ORDER_HI   = 6;
  localparam int CTL_OMIRROR    = 7;
endpackage

// File: rtl/crcx_lane_pick.sv
module crcx_lane_pick #(
  parameter int W  = crcx_pkg::CRC_W,
  parameter int LW = crcx_pkg::LANE_W,
  localparam int LANES = W / LW
) (
  input  logic [LANES-1:0] be,
  input  logic [W-1:0]     wdata,
  output logic             is_word,
  output logic             is_byte,
  output logic [LW-1:0]    byte_val
);
  assign is_word = &be;
  assign is_byte = $onehot(be);

  always_comb begin
    byte_val = '0;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) byte_val = byte_val | wdata[i*LW +: LW];
    end
  end
endmodule

// File: rtl/crcx_in_shape.sv
module crcx_in_shape #(
  parameter int W  = crcx_pkg::CRC_W,
  parameter int LW = crcx_pkg::LANE_W,
  localparam int LANES = W / LW
) (
  input  logic [1:0]    order,
  input  logic          is_word,
  input  logic [W-1:0]  wdata,
  input  logic [LW-1:0] byte_val,
  output logic [W-1:0]  fold_din
);
  logic [W-1:0]  mir_full;
  logic [W-1:0]  mir_lane;
  logic [LW-1:0] mir_byte;

  for (genvar i = 0; i < W; i++) begin : g_full
    assign mir_full[i] = wdata[W-1-i];
  end
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar b = 0; b < LW; b++) begin : g_bit
      assign mir_lane[l*LW + b] = wdata[l*LW + LW-1-b];
    end
  end
  for (genvar b = 0; b < LW; b++) begin : g_byte
    assign mir_byte[b] = byte_val[LW-1-b];
  end

  always_comb begin
    if (is_word) begin
      unique case (order)
        2'b11:   fold_din = mir_full;
        2'b01:   fold_din = mir_lane;
        default: fold_din = wdata;
      endcase
    end else begin
      fold_din = {(order[0] ? mir_byte : byte_val), {(W-LW){1'b0}}};
    end
  end
endmodule

// File: rtl/crcx_fold.sv
module crcx_fold #(
  parameter int W  = crcx_pkg::CRC_W,
  parameter int LW = crcx_pkg::LANE_W
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] poly,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt_word,
  output logic [W-1:0] nxt_byte
);
  logic [W-1:0] stage [W+1];

  assign stage[0] = acc;
  for (genvar i = 0; i < W; i++) begin : g_step
    logic fb;
    assign fb = stage[i][W-1] ^ din[W-1-i];
    assign stage[i+1] = {stage[i][W-2:0], 1'b0} ^ (fb ? poly : '0);
  end

  assign nxt_word = stage[W];
  assign nxt_byte = stage[LW];
endmodule

// File: rtl/crc_reg_engine.sv
module crc_reg_engine #(
  parameter int           W        = crcx_pkg::CRC_W,
  parameter logic [W-1:0] INIT_RST = '1,
  parameter logic [W-1:0] POLY_RST = 32'h04C11DB7,
  localparam int LW    = crcx_pkg::LANE_W,
  localparam int LANES = W / LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_word_addr,
  input  logic             bus_we,
  input  logic [LANES-1:0] bus_be,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata
);
  import crcx_pkg::*;

  reg_sel_e     sel;
  logic         wr_data, wr_ctl, wr_init, wr_poly, ctl_lane;
  logic         is_word, is_byte;
  logic [LW-1:0] byte_val;
  logic [W-1:0] fold_din, nxt_word, nxt_byte, acc_mir;
  logic [W-1:0] acc_q, init_q, poly_q;
  logic [1:0]   order_q;
  logic         omir_q;

  assign sel      = reg_sel_e'(bus_word_addr);
  assign wr_data  = bus_we && (sel == SEL_DATA);
  assign wr_ctl   = bus_we && (sel == SEL_CTRL);
  assign wr_init  = bus_we && (sel == SEL_INIT);
  assign wr_poly  = bus_we && (sel == SEL_POLY);
  assign ctl_lane = wr_ctl && bus_be[0];

  crcx_lane_pick #(.W(W), .LW(LW)) u_pick (
    .be(bus_be), .wdata(bus_wdata),
    .is_word(is_word), .is_byte(is_byte), .byte_val(byte_val)
  );

  crcx_in_shape #(.W(W), .LW(LW)) u_shape (
    .order(order_q), .is_word(is_word), .wdata(bus_wdata),
    .byte_val(byte_val), .fold_din(fold_din)
  );

  crcx_fold #(.W(W), .LW(LW)) u_fold (
    .acc(acc_q), .poly(poly_q), .din(fold_din),
    .nxt_word(nxt_word), .nxt_byte(nxt_byte)
  );

  // Remainder: reload has priority (different address, so never concurrent with data)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= INIT_RST;
    end else if (ctl_lane && bus_wdata[CTL_RELOAD_BIT]) begin
      acc_q <= init_q;
    end else if (wr_data && is_word) begin
      acc_q <= nxt_word;
    end else if (wr_data && is_byte) begin
      acc_q <= nxt_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      order_q <= 2'b00;
      omir_q  <= 1'b0;
    end else if (ctl_lane) begin
      order_q <= bus_wdata[CTL_ORDER_HI:CTL_ORDER_LO];
      omir_q  <= bus_wdata[CTL_OMIRROR];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cfg_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        init_q[l*LW +: LW] <= INIT_RST[l*LW +: LW];
        poly_q[l*LW +: LW] <= POLY_RST[l*LW +: LW];
      end else begin
        if (wr_init && bus_be[l]) init_q[l*LW +: LW] <= bus_wdata[l*LW +: LW];
        if (wr_poly && bus_be[l]) poly_q[l*LW +: LW] <= bus_wdata[l*LW +: LW];
      end
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_omir
    assign acc_mir[i] = acc_q[W-1-i];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_DATA: bus_rdata = omir_q ? acc_mir : acc_q;
      SEL_CTRL: begin
        bus_rdata[CTL_OMIRROR]               = omir_q;
        bus_rdata[CTL_ORDER_HI:CTL_ORDER_LO] = order_q;
      end
      SEL_INIT: bus_rdata = init_q;
      SEL_POLY: bus_rdata = poly_q;
      default:  bus_rdata = '0;
    endcase
  end

  // R2: a reload write makes the remainder equal the starting value seen in that cycle
  p_reload_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_lane && bus_wdata[CTL_RELOAD_BIT]) |=> (acc_q == $past(init_q)));

  // R5: strobe patterns other than one lane or all lanes leave the remainder alone
  p_bad_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !$onehot(bus_be) && !(&bus_be)) |=> $stable(acc_q));

  // R8: a control write without reload keeps the remainder
  p_keep_rem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !(bus_be[0] && bus_wdata[CTL_RELOAD_BIT])) |=> $stable(acc_q));

  // R3: the polynomial only changes when written
  p_poly_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_poly) |=> $stable(poly_q));

  // R4: with no write at all the remainder holds
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we) |=> $stable(acc_q));
endmodule

// File: tb/tb_crc_reg_engine.sv
`timescale 1ns/1ps
module tb_crc_reg_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        we = 1'b0;
  logic [3:0]  be = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  crc_reg_engine dut (
    .clk(clk), .rst_n(rst_n), .bus_word_addr(addr), .bus_we(we),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_acc, m_init, m_poly;
  logic [1:0]  m_order;
  logic        m_omir;

  function automatic logic [31:0] mstep(input logic [31:0] a, input logic [31:0] p, input logic b);
    mstep = (a[31] ^ b) ? ((a << 1) ^ p) : (a << 1);
  endfunction

  function automatic logic [31:0] mirror32(input logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = v[31-k];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: m_read = m_omir ? mirror32(m_acc) : m_acc;
      2'd1: m_read = {24'h0, m_omir, m_order, 5'h0};
      2'd2: m_read = m_init;
      default: m_read = m_poly;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 32'hFFFF_FFFF; m_init = 32'hFFFF_FFFF; m_poly = 32'h04C1_1DB7;
      m_order = 2'b00; m_omir = 1'b0;
    end else if (we) begin
      case (addr)
        2'd0: begin
          if (be == 4'hF) begin
            if (m_order == 2'b11) begin
              for (int k = 0; k < 32; k++) m_acc = mstep(m_acc, m_poly, wdata[k]);
            end else if (m_order == 2'b01) begin
              for (int l = 3; l >= 0; l--)
                for (int k = 0; k < 8; k++) m_acc = mstep(m_acc, m_poly, wdata[8*l+k]);
            end else begin
              for (int k = 31; k >= 0; k--) m_acc = mstep(m_acc, m_poly, wdata[k]);
            end
          end else if (be == 4'h1 || be == 4'h2 || be == 4'h4 || be == 4'h8) begin
            int ln;
            logic [7:0] bv;
            ln = (be == 4'h1) ? 0 : (be == 4'h2) ? 1 : (be == 4'h4) ? 2 : 3;
            bv = wdata[8*ln +: 8];
            if (m_order[0]) begin
              for (int k = 0; k < 8; k++) m_acc = mstep(m_acc, m_poly, bv[k]);
            end else begin
              for (int k = 7; k >= 0; k--) m_acc = mstep(m_acc, m_poly, bv[k]);
            end
          end
        end
        2'd1: if (be[0]) begin
          if (wdata[0]) m_acc = m_init;
          m_order = wdata[6:5];
          m_omir  = wdata[7];
        end
        2'd2: for (int l = 0; l < 4; l++) if (be[l]) m_init[8*l +: 8] = wdata[8*l +: 8];
        default: for (int l = 0; l < 4; l++) if (be[l]) m_poly[8*l +: 8] = wdata[8*l +: 8];
      endcase
    end
  end

  // every-clock comparison (covers the read seen during a data write)
  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      n_run++;
      if (rdata !== m_read(addr)) begin
        n_fail++;
        $display("FAIL R4 clock compare addr=%0d actual=%h expected=%h", addr, rdata, m_read(addr));
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(posedge clk); #2;
    addr = a; be = b; wdata = d; we = 1'b1;
    @(posedge clk); #2;
    we = 1'b0; be = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(posedge clk); #2;
    addr = a; we = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wr_byte(input int lane, input logic [7:0] b);
    wr(2'd0, 4'(1 << lane), 32'(b) << (8*lane));
  endtask

  task automatic feed_bytes();
    string s = "123456789";
    for (int i = 0; i < 9; i++) wr_byte(i % 4, s[i]);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v, prev;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    mon_on = 1'b1;

    rd(2'd0, v); chk("R1 remainder after reset", v, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R1 control after reset", v, 32'h0);
    rd(2'd2, v); chk("R1 init after reset", v, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R1 poly after reset", v, 32'h04C1_1DB7);

    // R4/R5: plain MSB-first, bytes on rotating lanes
    feed_bytes();
    rd(2'd0, v); chk("R4 R5 byte feed check value", v, 32'h0376_E6E7);
    wr(2'd1, 4'h1, 32'h1);
    rd(2'd0, v); chk("R2 reload", v, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R2 reload bit reads 0", v, 32'h0);

    // R4 words MSB-first then a byte on lane 2
    wr(2'd0, 4'hF, 32'h3132_3334);
    wr(2'd0, 4'hF, 32'h3536_3738);
    wr(2'd0, 4'h4, 32'h0039_0000);
    rd(2'd0, v); chk("R4 word feed check value", v, 32'h0376_E6E7);

    // R9 byte-only reflected
    wr(2'd1, 4'h1, 32'hA1);
    feed_bytes();
    rd(2'd0, v); chk("R9 byte-only standard CRC-32", v ^ 32'hFFFF_FFFF, 32'hCBF4_3926);

    // R9/R6 mixed: full-word mirroring for words, byte mirroring for the tail (R8: no reload)
    wr(2'd1, 4'h1, 32'hE1);
    wr(2'd0, 4'hF, 32'h3433_3231);
    wr(2'd0, 4'hF, 32'h3837_3635);
    wr(2'd1, 4'h1, 32'hA0);
    wr_byte(0, 8'h39);
    rd(2'd0, v); chk("R9 R6 R8 mixed standard CRC-32", v ^ 32'hFFFF_FFFF, 32'hCBF4_3926);
    prev = v;

    // R7: turning output mirroring off exposes the raw remainder
    wr(2'd1, 4'h1, 32'h20);
    rd(2'd0, v); chk("R7 output mirroring removed", v, mirror32(prev));
    rd(2'd1, v); chk("R8 control readback", v, 32'h20);

    // R5 ignored strobe patterns
    rd(2'd0, prev);
    wr(2'd0, 4'h3, 32'hDEAD_BEEF);
    wr(2'd0, 4'h0, 32'h1234_5678);
    wr(2'd0, 4'hA, 32'h5555_AAAA);
    rd(2'd0, v); chk("R5 illegal strobes ignored", v, prev);

    // R3 lane writes
    wr(2'd2, 4'h1, 32'h1234_5678);
    rd(2'd2, v); chk("R3 init lane 0 only", v, 32'hFFFF_FF78);
    wr(2'd3, 4'hF, 32'h1EDC_6F41);
    rd(2'd3, v); chk("R3 poly full write", v, 32'h1EDC_6F41);
    wr(2'd3, 4'h8, 32'h0400_0000);
    rd(2'd3, v); chk("R3 poly lane 3 only", v, 32'h04DC_6F41);
    wr(2'd1, 4'h1, 32'h01);
    rd(2'd0, v); chk("R2 reload uses new init", v, 32'hFFFF_FF78);

    // R6 per-byte mirroring of a word, with the changed polynomial
    wr(2'd1, 4'h1, 32'h20);
    wr(2'd0, 4'hF, 32'hC3A5_0F81);
    rd(2'd0, v); chk("R6 lane-mirrored word", v, m_read(2'd0));
    wr(2'd1, 4'h1, 32'h40);
    wr(2'd0, 4'hF, 32'h0102_0408);
    rd(2'd0, v); chk("R6 order 10 treated as none", v, m_read(2'd0));

    // R10 reload and reorder in one write
    wr(2'd1, 4'h1, 32'h61);
    rd(2'd0, v); chk("R10 reload with reorder", v, 32'hFFFF_FF78);
    wr(2'd0, 4'hF, 32'h8000_0001);
    rd(2'd0, v); chk("R10 next word uses new order", v, m_read(2'd0));
    wr(2'd0, 4'h2, 32'h0000_9600);
    rd(2'd0, v); chk("R6 mirrored byte on lane 1", v, m_read(2'd0));

    // control write on lane 1 only does nothing (R8)
    rd(2'd0, prev);
    wr(2'd1, 4'h2, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R8 control without lane 0 ignored", v, prev);

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule